// File: doc/BRIEF.md
# Floppy controller command sequencer

This block is the host-facing front of a dual-drive floppy controller. It holds two registers: a control/status word and a data word. The host selects the register with one address bit and writes it with per-byte enables. A control write that carries GO while the sequencer is idle starts a function. The sequencer then asks for that function's parameter words one at a time. It raises a transfer-request flag, takes one data-register write, and waits a fixed settling delay before it either asks for the next word or hands off to the back end.

The hand-off is a one-cycle start pulse. With it go the latched function, drive, density, address extension and the collected parameters. Media access, DMA and status assembly all sit behind that port. The back end answers with a done strobe, an error flag and a status word. On that answer the block sets DONE, may set ERROR, loads the status word into the data register and raises an interrupt request when it is enabled. A control write with the INIT bit set returns the whole block to its reset state.

Top module: `fdc_seq`

## Requirements
- R1: A control read returns {ERROR[15], 0[14], EXT[13:12], 1[11], 0[10:9], DENSITY[8], XREQ[7], IE[6], DONE[5], DRIVE[4], FUNC[3:1], 0[0]}. Bit 0 of a write is GO. After reset the value is 0x0800. Address bit 0 selects the control register and 1 selects the data register.
- R2: A control write with GO=1 while idle is accepted. It clears DONE, ERROR and the interrupt, and latches FUNC, DRIVE, DENSITY, EXT and IE. If the function takes parameters it sets XREQ.
- R3: A control write whose merged value has bit 14 set returns every register to its reset state. Nothing else in that write takes effect, and a pending sequence is abandoned without a start pulse.
- R4: The parameter count depends on the function. Codes 0 (fill) and 1 (empty) take a word count, masked to 8 bits, then a full 16-bit address. Codes 2, 3 and 6 (write, read, write deleted) take a sector, masked to 7 bits, then a track, masked to 8 bits. Code 4 (set density) takes a confirmation byte, masked to 8 bits. Code 7 (extended status) takes a full 16-bit address. Code 5 (read status) takes none. The first parameter appears on par0_o and the second on par1_o; a slot that is not used reads 0.
- R5: The data register ignores a write with byte enable 0 clear. When the sequencer is not idle it also ignores writes made while XREQ is clear. When idle, a write is stored directly, with the high byte taken as 0 if byte enable 1 is clear.
- R6: An accepted parameter write clears XREQ. XFER_DLY cycles later the sequence advances. A parameter other than the last sets XREQ again. The last one produces a start pulse lasting exactly one cycle.
- R7: Read status (code 5) produces its start pulse in the cycle right after it is accepted, with XREQ never set.
- R8: A control write that starts no function updates FUNC, DRIVE, IE, DENSITY and EXT only, using the byte lanes that are enabled. The interrupt becomes IE and DONE.
- R9: A done_i strobe while waiting on the back end sets DONE and sets ERROR to done_err_i. It loads done_data_i into the data register, raises the interrupt if IE is set and returns the sequencer to idle.
- R10: A control write with GO while the sequencer is not idle starts nothing; it acts only as a field update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects the control register, 1 the data register |
| reg_be_i | input | 2 | Byte enables (bit 1 is the high byte) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |
| start_o | output | 1 | One-cycle pulse that starts the back end |
| func_o | output | 3 | Latched function code |
| drive_o | output | 1 | Latched drive select |
| dens_o | output | 1 | Latched density select |
| ext_o | output | 2 | Latched address extension |
| par0_o | output | 16 | First parameter, masked |
| par1_o | output | 16 | Second parameter, masked |
| done_i | input | 1 | Back-end completion strobe |
| done_err_i | input | 1 | Completion reports an error |
| done_data_i | input | 16 | Status word loaded into the data register on completion |

## Verification
Register writes take effect at the edge that samples them. Control and data read-backs are therefore checked at the falling edge just after that edge. XREQ falls in that same cycle and rises again exactly XFER_DLY edges after the parameter write. The bench checks XREQ still low one cycle before that edge and high at it. Read status shows its start pulse already at the falling edge after acceptance. For the other functions, start pulses are compared by a monitor against a queue of expected function and parameter values, whenever they arrive. Any pulse that arrives with the queue empty is a failure, which is how the bench shows that GO while busy and INIT give no stray start.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PARAM, ST_DELAY, ST_BUSY} seq_state_e;

  localparam logic [2:0] FN_FILL  = 3'd0;
  localparam logic [2:0] FN_EMPTY = 3'd1;
  localparam logic [2:0] FN_WRITE = 3'd2;
  localparam logic [2:0] FN_READ  = 3'd3;
  localparam logic [2:0] FN_DENS  = 3'd4;
  localparam logic [2:0] FN_STAT  = 3'd5;
  localparam logic [2:0] FN_WDEL  = 3'd6;
  localparam logic [2:0] FN_XSTAT = 3'd7;

  function automatic logic [1:0] n_params(input logic [2:0] fn);
    case (fn)
      FN_STAT:          n_params = 2'd0;
      FN_DENS, FN_XSTAT: n_params = 2'd1;
      default:          n_params = 2'd2;
    endcase
  endfunction

  function automatic logic [15:0] param_mask(input logic [2:0] fn, input logic idx);
    case (fn)
      FN_FILL, FN_EMPTY:          param_mask = idx ? 16'hFFFF : 16'h00FF;
      FN_WRITE, FN_READ, FN_WDEL: param_mask = idx ? 16'h00FF : 16'h007F;
      FN_DENS:                    param_mask = 16'h00FF;
      default:                    param_mask = 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/fdc_lane_merge.sv
module fdc_lane_merge #(
  parameter int LANES = 2,
  parameter int LW    = 8,
  localparam int W    = LANES * LW
) (
  input  logic [W-1:0]     old_i,
  input  logic [W-1:0]     new_i,
  input  logic [LANES-1:0] be_i,
  output logic [W-1:0]     merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*LW +: LW] = be_i[l] ? new_i[l*LW +: LW] : old_i[l*LW +: LW];
  end
endmodule

// File: rtl/fdc_xfer_delay.sv
module fdc_xfer_delay #(
  parameter int DLY = 4,
  localparam int CW = $clog2(DLY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic kick_i,
  output logic fire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (kick_i)        cnt_q <= CW'(DLY);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign fire_o = (cnt_q == CW'(1));
endmodule

// File: rtl/fdc_param_store.sv
module fdc_param_store #(
  parameter int NPAR = 2,
  parameter int DW   = 16,
  localparam int IW  = (NPAR > 1) ? $clog2(NPAR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [IW-1:0]            idx_i,
  input  logic [DW-1:0]            val_i,
  output logic [NPAR-1:0][DW-1:0]  par_o
);
  for (genvar s = 0; s < NPAR; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         par_o[s] <= '0;
      else if (clr_i)                      par_o[s] <= '0;
      else if (wr_i && idx_i == IW'(s))    par_o[s] <= val_i;
    end
  end
endmodule

// File: rtl/fdc_seq.sv
module fdc_seq
  import fdc_pkg::*;
#(
  parameter int XFER_DLY = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_addr_i,
  input  logic [1:0]  reg_be_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o,
  output logic        start_o,
  output logic [2:0]  func_o,
  output logic        drive_o,
  output logic        dens_o,
  output logic [1:0]  ext_o,
  output logic [15:0] par0_o,
  output logic [15:0] par1_o,
  input  logic        done_i,
  input  logic        done_err_i,
  input  logic [15:0] done_data_i
);
  localparam int NPAR = 2;
  localparam int DW   = 16;

  seq_state_e st_q;
  logic [2:0]  func_q;
  logic [1:0]  ext_q;
  logic        drv_q, den_q, ie_q, done_q, err_q, tr_q, irq_q, start_q, idx_q;
  logic [DW-1:0] dbr_q, csr_rd, merged;
  logic [NPAR-1:0][DW-1:0] par;

  logic seq_idle, seq_busy, csr_wr, init_wr, accept, data_acc, fire, ie_d, last_par;
  logic unused_bits;

  assign csr_rd = {err_q, 1'b0, ext_q, 1'b1, 2'b00, den_q, tr_q, ie_q, done_q,
                   drv_q, func_q, 1'b0};

  fdc_lane_merge #(.LANES(2), .LW(8)) i_merge (
    .old_i(csr_rd), .new_i(reg_wdata_i), .be_i(reg_be_i), .merged_o(merged)
  );

  assign seq_idle = (st_q == ST_IDLE);
  assign seq_busy = (st_q == ST_BUSY);
  assign csr_wr   = reg_we_i && !reg_addr_i;
  assign init_wr  = csr_wr && merged[14];
  assign accept   = csr_wr && !merged[14] && merged[0] && seq_idle;
  assign data_acc = reg_we_i && reg_addr_i && reg_be_i[0] && (seq_idle || tr_q);
  assign ie_d     = (csr_wr && !accept) ? merged[6] : ie_q;
  assign last_par = ({1'b0, idx_q} + 2'd1) >= n_params(func_q);
  assign unused_bits = ^{merged[15], merged[11:9], merged[7], merged[5]};

  fdc_xfer_delay #(.DLY(XFER_DLY)) i_dly (
    .clk_i, .rst_ni, .clr_i(init_wr),
    .kick_i(data_acc && !seq_idle), .fire_o(fire)
  );

  fdc_param_store #(.NPAR(NPAR), .DW(DW)) i_par (
    .clk_i, .rst_ni, .clr_i(accept || init_wr), .wr_i(fire),
    .idx_i(idx_q), .val_i(dbr_q & param_mask(func_q, idx_q)), .par_o(par)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; func_q <= '0; ext_q <= '0; drv_q <= 1'b0; den_q <= 1'b0;
      ie_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; tr_q <= 1'b0; irq_q <= 1'b0;
      start_q <= 1'b0; idx_q <= 1'b0; dbr_q <= '0;
    end else if (init_wr) begin
      st_q <= ST_IDLE; func_q <= '0; ext_q <= '0; drv_q <= 1'b0; den_q <= 1'b0;
      ie_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; tr_q <= 1'b0; irq_q <= 1'b0;
      start_q <= 1'b0; idx_q <= 1'b0; dbr_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (csr_wr) begin
        func_q <= merged[3:1];
        drv_q  <= merged[4];
        ie_q   <= merged[6];
        den_q  <= merged[8];
        ext_q  <= merged[13:12];
        if (accept) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
          irq_q  <= 1'b0;
          idx_q  <= 1'b0;
          if (n_params(merged[3:1]) == 2'd0) begin
            st_q    <= ST_BUSY;
            start_q <= 1'b1;
          end else begin
            st_q <= ST_PARAM;
            tr_q <= 1'b1;
          end
        end else begin
          irq_q <= merged[6] && done_q;
        end
      end
      if (data_acc) begin
        dbr_q <= {reg_be_i[1] ? reg_wdata_i[15:8] : 8'h00, reg_wdata_i[7:0]};
        if (!seq_idle) begin
          tr_q <= 1'b0;
          st_q <= ST_DELAY;
        end
      end
      if (fire) begin
        if (last_par) begin
          st_q    <= ST_BUSY;
          start_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          tr_q  <= 1'b1;
          st_q  <= ST_PARAM;
        end
      end
      if (seq_busy && done_i) begin
        st_q   <= ST_IDLE;
        done_q <= 1'b1;
        err_q  <= done_err_i;
        irq_q  <= ie_d;
        dbr_q  <= done_data_i;
      end
    end
  end

  assign reg_rdata_o = reg_addr_i ? dbr_q : csr_rd;
  assign irq_o   = irq_q;
  assign start_o = start_q;
  assign func_o  = func_q;
  assign drive_o = drv_q;
  assign dens_o  = den_q;
  assign ext_o   = ext_q;
  assign par0_o  = par[0];
  assign par1_o  = par[1];
endmodule

// File: rtl/fdc_seq_chk.sv
module fdc_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic        reg_addr_i,
  input logic [1:0]  reg_be_i,
  input logic [15:0] reg_wdata_i,
  input logic        irq_o,
  input logic        start_o,
  input logic        done_i,
  input logic        done_q,
  input logic        ie_q,
  input logic        err_q,
  input logic        tr_q,
  input logic        seq_idle,
  input logic        seq_busy,
  input logic [15:0] dbr_q
);
  logic init_w;
  assign init_w = reg_we_i && !reg_addr_i && reg_be_i[1] && reg_wdata_i[14];

  AST_IRQ_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_q && ie_q)) else $error("irq without done and ie"); // R8

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o) else $error("start longer than one cycle"); // R6

  AST_INIT_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_w |=> (seq_idle && !done_q && !tr_q && !irq_o && !start_o)) else $error("init"); // R3

  AST_DATA_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i && !seq_idle && !tr_q && !done_i) |=> $stable(dbr_q))
    else $error("data write not ignored"); // R5

  AST_ACCEPT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i && reg_be_i == 2'b11 && !reg_wdata_i[14] && reg_wdata_i[0]
     && seq_idle) |=> (!done_q && !err_q && !irq_o)) else $error("accept"); // R2

  AST_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && done_i && !init_w) |=> (done_q && seq_idle)) else $error("done"); // R9
endmodule

bind fdc_seq fdc_seq_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_be_i(reg_be_i), .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .start_o(start_o),
  .done_i(done_i), .done_q(done_q), .ie_q(ie_q), .err_q(err_q), .tr_q(tr_q),
  .seq_idle(seq_idle), .seq_busy(seq_busy), .dbr_q(dbr_q)
);

// File: tb/test_fdc_seq.sv
module test_fdc_seq;
  localparam int DLY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, addr = 1'b0, d_done = 1'b0, d_err = 1'b0;
  logic [1:0]  be = 2'b11;
  logic [15:0] wdata = '0, d_data = '0;
  logic [15:0] rdata, par0, par1;
  logic irq, start, drive, dens;
  logic [2:0] func;
  logic [1:0] ext;

  int n_chk = 0, n_err = 0, n_start = 0;
  logic [34:0] exp_q[$];

  always #4 clk = ~clk;

  fdc_seq #(.XFER_DLY(DLY)) i_fdc_seq (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_be_i(be),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .start_o(start),
    .func_o(func), .drive_o(drive), .dens_o(dens), .ext_o(ext), .par0_o(par0),
    .par1_o(par1), .done_i(d_done), .done_err_i(d_err), .done_data_i(d_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare each start pulse against the expected queue
  always @(negedge clk) begin
    if (rst_n && start) begin
      n_start++;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R10 actual start func %0d expected no start", func);
      end else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        if ({func, par0, par1} !== e) begin
          n_err++;
          $display("FAIL R4 actual %h expected %h", {func, par0, par1}, e);
        end
      end
    end
  end

  task automatic wr(input logic a, input logic [1:0] b, input logic [15:0] d);
    we = 1'b1; addr = a; be = b; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; be = 2'b11;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_tr();
    logic [15:0] v;
    for (int i = 0; i < 50; i++) begin
      rd(1'b0, v);
      if (v[7]) return;
      @(negedge clk);
    end
  endtask

  task automatic wait_start(input int target);
    for (int i = 0; i < 50 && n_start < target; i++) @(negedge clk);
  endtask

  task automatic complete(input logic e, input logic [15:0] d);
    d_done = 1'b1; d_err = e; d_data = d;
    @(negedge clk);
    d_done = 1'b0; d_err = 1'b0;
  endtask

  task automatic run2(input logic [15:0] cmd, input logic [15:0] p0, input logic [15:0] p1,
                      input logic [34:0] e);
    int t;
    t = n_start + 1;
    exp_q.push_back(e);
    wr(1'b0, 2'b11, cmd);
    wait_tr();
    wr(1'b1, 2'b11, p0);
    if (e[34:32] != 3'd4 && e[34:32] != 3'd7) begin
      wait_tr();
      wr(1'b1, 2'b11, p1);
    end
    wait_start(t);
    chk("R4 start seen", 16'(n_start), 16'(t));
    complete(1'b0, 16'h0000);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); chk("R1 reset csr", v, 16'h0800);
    chk("R1 reset irq", 16'(irq), 16'h0);

    // fill with exact XREQ timing
    exp_q.push_back({3'd0, 16'h0034, 16'hBEEF});
    wr(1'b0, 2'b11, 16'h0041);
    rd(1'b0, v); chk("R2 fill accept", v, 16'h08C0);
    wr(1'b1, 2'b11, 16'h1234);
    rd(1'b0, v); chk("R6 xreq clears", v[7], 1'b0);
    repeat (DLY - 1) @(negedge clk);
    rd(1'b0, v); chk("R6 xreq still low", v[7], 1'b0);
    @(negedge clk);
    rd(1'b0, v); chk("R6 xreq again", v[7], 1'b1);
    wr(1'b1, 2'b11, 16'hBEEF);
    wait_start(1);
    complete(1'b0, 16'h0084);
    rd(1'b0, v); chk("R9 done csr", v, 16'h0860);
    chk("R9 irq", 16'(irq), 16'h1);
    rd(1'b1, v); chk("R9 status word", v, 16'h0084);

    // interrupt enable updates
    wr(1'b0, 2'b11, 16'h0000);
    rd(1'b0, v); chk("R8 ie cleared", v, 16'h0820);
    chk("R8 irq dropped", 16'(irq), 16'h0);
    wr(1'b0, 2'b11, 16'h0040);
    chk("R8 irq raised", 16'(irq), 16'h1);

    // read with ignored writes, GO while busy, error completion
    exp_q.push_back({3'd3, 16'h007F, 16'h00AB});
    wr(1'b0, 2'b11, 16'h0107);
    rd(1'b0, v); chk("R2 read accept", v, 16'h0986);
    chk("R2 irq cleared", 16'(irq), 16'h0);
    wr(1'b1, 2'b10, 16'h1234);
    rd(1'b1, v); chk("R5 high byte ignored", v, 16'h0084);
    rd(1'b0, v); chk("R5 xreq kept", v[7], 1'b1);
    wr(1'b1, 2'b11, 16'h00FF);
    wr(1'b1, 2'b11, 16'h5555);
    rd(1'b1, v); chk("R5 no-xreq write ignored", v, 16'h00FF);
    wait_tr();
    wr(1'b1, 2'b11, 16'h01AB);
    wait_start(2);
    wr(1'b0, 2'b11, 16'h0107);
    repeat (10) @(negedge clk);
    chk("R10 no second start", 16'(n_start), 16'd2);
    complete(1'b1, 16'h0011);
    rd(1'b0, v); chk("R9 error csr", v, 16'h8926);
    chk("R9 irq off when ie clear", 16'(irq), 16'h0);

    // remaining functions
    run2(16'h0009, 16'h1F49, 16'h0000, {3'd4, 16'h0049, 16'h0000});
    exp_q.push_back({3'd5, 16'h0000, 16'h0000});
    wr(1'b0, 2'b11, 16'h000B);
    chk("R7 immediate start", 16'(start), 16'h1);
    rd(1'b0, v); chk("R7 no xreq", v, 16'h080A);
    complete(1'b0, 16'h0000);
    run2(16'h000F, 16'hABCD, 16'h0000, {3'd7, 16'hABCD, 16'h0000});
    run2(16'h001D, 16'h0080, 16'h0150, {3'd6, 16'h0000, 16'h0050});
    run2(16'h0003, 16'h0A0B, 16'h2000, {3'd1, 16'h000B, 16'h2000});
    chk("R4 drive latched", 16'(drive), 16'h0);

    // INIT abandons a pending sequence
    wr(1'b0, 2'b11, 16'h0045);
    wr(1'b0, 2'b11, 16'h4045);
    rd(1'b0, v); chk("R3 init csr", v, 16'h0800);
    chk("R3 init irq", 16'(irq), 16'h0);
    repeat (20) @(negedge clk);
    chk("R3 no start after init", 16'(exp_q.size()), 16'h0);

    // idle data writes and byte-lane control write
    wr(1'b1, 2'b11, 16'h0102);
    rd(1'b1, v); chk("R5 idle data word", v, 16'h0102);
    wr(1'b1, 2'b01, 16'hFF77);
    rd(1'b1, v); chk("R5 idle low byte", v, 16'h0077);
    wr(1'b0, 2'b10, 16'h3000);
    rd(1'b0, v); chk("R8 ext by high lane", v, 16'h3800);
    chk("R8 ext port", 16'(ext), 16'h3);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule